// File: doc/BRIEF.md
# Configurable Initial-Latency Burst Controller

This block governs how many clocks a burst read waits before its first word. Software sets the wait by issuing a three-write unlock-and-configure sequence on a simple write bus. The third write carries a latency code in a field of its address, not on the data lines. The block clamps that code into the legal range of total cycles and stores it. Reset restores the longest latency.

Each time the address-valid strobe is sampled high, the block loads the stored latency into a down-counter. When the counter runs out, a one-cycle first-word pulse marks the moment the first burst word is available. From then on a ready handshake is driven high whenever output enable (active low) is asserted. Ready stays low from the strobe until the count runs out. A fresh strobe abandons any count in progress and starts over. Array operations, status reads and the addressing of later burst words are handled elsewhere.

Top module: `burst_lat_ctrl`

## Requirements
- R1: The latency is updated only by three consecutive writes. The first has address bits [11:0] = 555h and data bits [7:0] = AAh. The second has address bits [11:0] = 2AAh and data bits [7:0] = 55h. The third has address bits [11:0] = 555h, and its address bits [16:12] carry the latency code.
- R2: A write that does not match the expected step of the sequence returns the decoder to its idle step and leaves the stored latency unchanged.
- R3: After reset, `lat_o` reads 7.
- R4: The stored total latency equals the 5-bit code, clamped to at least 2 and at most 7. Codes 2 and 3 are stored as 2 and 3.
- R5: If the strobe is sampled high at clock edge E0, `first_o` is high for exactly one cycle. That cycle begins at edge E(L), where L is the stored latency.
- R6: `rdy_o` is low from the edge after a strobe until the count expires. After expiry it equals the inverse of `oe_n`.
- R7: A strobe sampled while a count is running restarts the count from the full stored latency.
- R8: A strobe sampled at the same edge as the configuration write uses the latency held before that write. The next strobe uses the new value.
- R9: After reset and before any strobe, `rdy_o` and `first_o` are low whatever the level of `oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the command bus |
| wr_addr | input | ADDR_W | Write address; bits [16:12] hold the code on the third write |
| wr_data | input | DATA_W | Write data; bits [7:0] are compared during unlock |
| adv | input | 1 | Address-valid strobe, active high, sampled per clock |
| oe_n | input | 1 | Output enable, active low |
| lat_o | output | 3 | Stored total initial latency (2 to 7) |
| first_o | output | 1 | One-cycle pulse when the first word is available |
| rdy_o | output | 1 | Ready handshake |

## Verification
The hardest case to reach is the one where the count and the decoder interact. A strobe can arrive in the same cycle that a configuration write commits, or arrive again while a count is still running. From the ports, this needs precise alignment of the write strobe and the address-valid strobe on one edge. The bench therefore drives the third unlock write and the strobe at the same falling edge. It then measures the gap to `first_o` on two successive strobes, and it restarts a 5-cycle count midway to confirm that the early expiry never shows.

// File: rtl/burst_lat_pkg.sv
package burst_lat_pkg;
    localparam int LAT_W  = 3;
    localparam int CODE_W = 5;
    localparam int CODE_LSB = 12;
    localparam int MATCH_W = 12;
    localparam int KEY_W = 8;

    localparam logic [MATCH_W-1:0] ADDR_STEP_A = 12'h555;
    localparam logic [MATCH_W-1:0] ADDR_STEP_B = 12'h2AA;
    localparam logic [KEY_W-1:0]   KEY_A = 8'hAA;
    localparam logic [KEY_W-1:0]   KEY_B = 8'h55;

    localparam logic [LAT_W-1:0]  LAT_MIN = 3'd2;
    localparam logic [LAT_W-1:0]  LAT_MAX = 3'd7;
    localparam logic [CODE_W-1:0] CODE_MIN = 5'd2;
    localparam logic [CODE_W-1:0] CODE_MAX = 5'd7;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_KEY1 = 2'd1,
        SEQ_KEY2 = 2'd2
    } seq_e;

    function automatic logic [LAT_W-1:0] clamp_code(input logic [CODE_W-1:0] code);
        if (code < CODE_MIN)      return LAT_MIN;
        else if (code > CODE_MAX) return LAT_MAX;
        else                      return code[LAT_W-1:0];
    endfunction
endpackage

// File: rtl/lat_cmd_decode.sv
module lat_cmd_decode
    import burst_lat_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [LAT_W-1:0]  lat_q_o
);
    typedef struct packed {
        seq_e             seq;
        logic [LAT_W-1:0] lat;
    } dec_t;

    dec_t st_d, st_q;

    logic [MATCH_W-1:0] addr_lo;
    logic [KEY_W-1:0]   data_lo;
    logic [CODE_W-1:0]  code;

    assign addr_lo = wr_addr[MATCH_W-1:0];
    assign data_lo = wr_data[KEY_W-1:0];
    assign code    = wr_addr[CODE_LSB +: CODE_W];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.seq = SEQ_IDLE;
            unique case (st_q.seq)
                SEQ_IDLE: if (addr_lo == ADDR_STEP_A && data_lo == KEY_A) st_d.seq = SEQ_KEY1;
                SEQ_KEY1: if (addr_lo == ADDR_STEP_B && data_lo == KEY_B) st_d.seq = SEQ_KEY2;
                SEQ_KEY2: if (addr_lo == ADDR_STEP_A) st_d.lat = clamp_code(code);
                default:  st_d.seq = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.seq <= SEQ_IDLE;
            st_q.lat <= LAT_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_q_o = st_q.lat;

    // R3, R4: stored value always within the legal window
    a_r4_lat_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lat >= LAT_MIN) && (st_q.lat <= LAT_MAX));

    // R1, R2: latency only moves after a write seen in the final step
    a_r1_update_needs_seq: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.lat) |-> $past(wr_en && st_q.seq == SEQ_KEY2));

    // R2: any write leaves the second step
    a_r2_key2_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st_q.seq == SEQ_KEY2) |=> (st_q.seq == SEQ_IDLE));
endmodule

// File: rtl/lat_wait_counter.sv
module lat_wait_counter
    import burst_lat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [LAT_W-1:0] lat_i,
    output logic             first_o,
    output logic             done_o
);
    localparam logic [LAT_W-1:0] CNT_ONE = 1;
    localparam logic [LAT_W-1:0] CNT_ZERO = '0;

    typedef struct packed {
        logic [LAT_W-1:0] cnt;
        logic             done;
        logic             first;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        c_d.first = 1'b0;
        if (adv) begin
            c_d.cnt  = lat_i;
            c_d.done = 1'b0;
        end else if (c_q.cnt > CNT_ONE) begin
            c_d.cnt = c_q.cnt - CNT_ONE;
        end else if (c_q.cnt == CNT_ONE) begin
            c_d.cnt   = CNT_ZERO;
            c_d.done  = 1'b1;
            c_d.first = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign first_o = c_q.first;
    assign done_o  = c_q.done;

    // R5: pulse lasts a single cycle
    a_r5_first_single: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.first |=> !c_q.first);

    // R7: running count steps down by one unless restarted
    a_r7_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && c_q.cnt > CNT_ONE) |=> (c_q.cnt == $past(c_q.cnt) - CNT_ONE));

    // R6: a strobe always clears the expired state
    a_r6_strobe_clears: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (!c_q.done && !c_q.first));
endmodule

// File: rtl/burst_lat_ctrl.sv
module burst_lat_ctrl
    import burst_lat_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              adv,
    input  logic              oe_n,
    output logic [LAT_W-1:0]  lat_o,
    output logic              first_o,
    output logic              rdy_o
);
    logic [LAT_W-1:0] lat_q;
    logic             done;

    lat_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .lat_q_o (lat_q)
    );

    lat_wait_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .lat_i   (lat_q),
        .first_o (first_o),
        .done_o  (done)
    );

    assign lat_o = lat_q;
    assign rdy_o = done & ~oe_n;

    // R6: ready is low in the cycle after any strobe
    a_r6_rdy_low_after_adv: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> !rdy_o);

    // R6: ready never high while output enable is released
    a_r6_rdy_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdy_o);
endmodule

// File: tb/test_burst_lat_ctrl.sv
module test_burst_lat_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [21:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        adv = 1'b0;
    logic        oe_n = 1'b1;
    logic [2:0]  lat_o;
    logic        first_o;
    logic        rdy_o;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    burst_lat_ctrl i_burst_lat_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .adv(adv), .oe_n(oe_n),
        .lat_o(lat_o), .first_o(first_o), .rdy_o(rdy_o)
    );

    // {code[4:0], expected total latency[2:0]}
    localparam logic [7:0] VEC [8] = '{
        {5'd0, 3'd2}, {5'd1, 3'd2}, {5'd2, 3'd2}, {5'd3, 3'd3},
        {5'd5, 3'd5}, {5'd7, 3'd7}, {5'd8, 3'd7}, {5'd31, 3'd7}
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [21:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic program_code(input logic [4:0] code);
        bus_wr(22'h000555, 16'h00AA);
        bus_wr(22'h0002AA, 16'h0055);
        bus_wr({5'd0, code, 12'h555}, 16'h0000);
    endtask

    // strobe for one cycle, return number of edges until first_o seen
    task automatic measure(output int gap);
        @(negedge clk); adv = 1'b1;
        @(negedge clk); adv = 1'b0;
        gap = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (first_o) begin gap = k; break; end
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int gap;
        oe_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check("R3 reset latency", lat_o, 7);
        check("R9 rdy low before strobe", rdy_o, 0);
        check("R9 first low before strobe", first_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 rdy still low, oe asserted", rdy_o, 0);
        measure(gap);
        check("R5 default gap", gap, 7);

        for (int i = 0; i < 8; i++) begin
            program_code(VEC[i][7:3]);
            #1;
            check("R4 R1 stored latency", lat_o, int'(VEC[i][2:0]));
            measure(gap);
            check("R5 first word gap", gap, int'(VEC[i][2:0]));
            #1;
            check("R6 rdy after expiry with oe low", rdy_o, 1);
        end

        // R2: wrong key data aborts; third write then ignored
        program_code(5'd4);
        bus_wr(22'h000555, 16'h00AA);
        bus_wr(22'h0002AA, 16'h0056);
        bus_wr({5'd0, 5'd6, 12'h555}, 16'h0000);
        #1; check("R2 bad key ignored", lat_o, 4);
        // R2: wrong third address ignored
        bus_wr(22'h000555, 16'h00AA);
        bus_wr(22'h0002AA, 16'h0055);
        bus_wr({5'd0, 5'd6, 12'h554}, 16'h0000);
        #1; check("R2 bad third addr ignored", lat_o, 4);

        // R6: oe high keeps rdy low, lowering oe raises it
        oe_n = 1'b1;
        measure(gap);
        #1; check("R6 rdy low with oe high", rdy_o, 0);
        oe_n = 1'b0; #1;
        check("R6 rdy follows oe", rdy_o, 1);

        // R7: restart mid-count
        program_code(5'd5);
        @(negedge clk); adv = 1'b1;
        @(negedge clk); adv = 1'b0;
        @(negedge clk); @(negedge clk);
        #1; check("R6 rdy low during count", rdy_o, 0);
        measure(gap);
        check("R7 restarted gap", gap, 5);

        // R8: strobe at same edge as config commit uses old latency
        bus_wr(22'h000555, 16'h00AA);
        bus_wr(22'h0002AA, 16'h0055);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {5'd0, 5'd3, 12'h555}; wr_data = '0; adv = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; adv = 1'b0;
        gap = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (first_o) begin gap = k; break; end
        end
        check("R8 same-edge strobe uses old latency", gap, 5);
        measure(gap);
        check("R8 next strobe uses new latency", gap, 3);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule